// File: doc/BRIEF.md
# Banked UART Host Register Interface

This block is the processor-facing register file of a classic byte-wide UART. A host reaches it through a single-cycle Wishbone classic slave port with a 3-bit address and an 8-bit data path. It holds the writable control registers: line control, interrupt enable, modem control, FIFO control, a 16-bit baud divisor and a scratch byte. It returns receive data and the line, modem and interrupt status composed from simple status inputs. It also issues one-clock strobes that pop the receive FIFO and push the transmit FIFO.

The address space is overlaid. The top bit of the line control register is a bank select. With that bit set, addresses 0 and 1 reach the two divisor bytes. With it clear, they reach the data path and the interrupt enable register. Address 2 identifies the pending interrupt on a read and loads FIFO control on a write. The serial shifters, the FIFOs and the baud generator sit outside the block. They are seen only through status and strobe ports.

Top module: `uart_regbank`

## Requirements
- R1: After reset, line control reads 0x03, interrupt enable 0x00, modem control 0x00, scratch 0x00 and the divisor output is 0x0000.
- R2: Every access is acknowledged by a one-clock ack in the cycle after strobe is first seen. Ack is never held two cycles in a row.
- R3: With line control bit 7 set, address 0 reads and writes divisor bits 7:0 and address 1 reads and writes divisor bits 15:8.
- R4: With line control bit 7 clear, a read of address 0 returns rx_data_i and raises rx_pop_o for exactly the ack cycle. A write of address 0 raises tx_push_o for the ack cycle with tx_data_o equal to the written byte.
- R5: With line control bit 7 clear, address 1 reads and writes the interrupt enable register.
- R6: A write to address 2 loads fcr_o. A read of address 2 returns the interrupt identification byte, never the FIFO control value.
- R7: Address 3 reads and writes line control whatever bit 7 holds. Address 4 reads and writes modem control.
- R8: Line status at address 5 has bit 0 = rx_ready_i, bit 5 = tx_fifo_empty_i whatever the shifter state, bit 6 = tx_fifo_empty_i AND tx_shift_idle_i, and all other bits 0.
- R9: A read of address 6 returns modem_status_i.
- R10: Writes to addresses 5 and 6 are acknowledged and change no register, output or strobe.
- R11: Address 7 is a scratch byte that reads back what was written.
- R12: Interrupt identification reads 0xC4 when interrupt enable bit 0 is set and rx_ready_i is 1. Otherwise it reads 0xC2 when enable bit 1 is set and tx_fifo_empty_i is 1. Otherwise it reads 0xC1.
- R13: With line control bit 7 set, accesses to address 0 raise neither rx_pop_o nor tx_push_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wb_cyc_i | input | 1 | Bus cycle valid |
| wb_stb_i | input | 1 | Bus strobe |
| wb_we_i | input | 1 | 1 = write |
| wb_adr_i | input | 3 | Register address |
| wb_dat_i | input | 8 | Write data |
| wb_dat_o | output | 8 | Read data, valid with ack |
| wb_ack_o | output | 1 | Transfer acknowledge |
| rx_data_i | input | 8 | Head byte of the receive FIFO |
| rx_ready_i | input | 1 | Receive FIFO holds data |
| tx_fifo_empty_i | input | 1 | Transmit FIFO is empty |
| tx_shift_idle_i | input | 1 | Transmit shifter has finished |
| modem_status_i | input | 8 | Modem status byte |
| rx_pop_o | output | 1 | Receive FIFO pop strobe |
| tx_push_o | output | 1 | Transmit FIFO push strobe |
| tx_data_o | output | 8 | Byte to push |
| ier_o | output | 8 | Interrupt enable register |
| fcr_o | output | 8 | FIFO control value last written |
| lcr_o | output | 8 | Line control register |
| mcr_o | output | 8 | Modem control register |
| divisor_o | output | 16 | Baud divisor |

## Verification
The assertions assume a master that keeps cyc, stb, we, address and data steady from the strobe until ack and then releases strobe. The ack-bound and single-pulse properties rely on that held strobe. The line-status property assumes the status inputs do not change between the strobe cycle and the ack cycle. The bench drives every access on the falling edge, holds it until it sees ack and then drops strobe. It changes the status inputs only between accesses, so each read samples a settled value.

// File: rtl/uart_regbank_pkg.sv
package uart_regbank_pkg;
  localparam int REG_W  = 8;
  localparam int ADR_W  = 3;
  localparam int DIV_W  = 2 * REG_W;
  localparam int BANK_BIT = REG_W - 1;

  localparam logic [ADR_W-1:0] ADR_DATA = 3'd0;
  localparam logic [ADR_W-1:0] ADR_IEN  = 3'd1;
  localparam logic [ADR_W-1:0] ADR_IDF  = 3'd2;
  localparam logic [ADR_W-1:0] ADR_LINE = 3'd3;
  localparam logic [ADR_W-1:0] ADR_MDM  = 3'd4;
  localparam logic [ADR_W-1:0] ADR_LST  = 3'd5;
  localparam logic [ADR_W-1:0] ADR_MST  = 3'd6;
  localparam logic [ADR_W-1:0] ADR_SCR  = 3'd7;

  localparam logic [REG_W-1:0] LINE_RESET = 8'h03;
  localparam logic [REG_W-1:0] ID_NONE    = 8'hC1;
  localparam logic [REG_W-1:0] ID_RXAVAIL = 8'hC4;
  localparam logic [REG_W-1:0] ID_TXEMPTY = 8'hC2;
endpackage

// File: rtl/uart_bus_port.sv
module uart_bus_port
  import uart_regbank_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic cyc_i,
  input  logic stb_i,
  input  logic we_i,
  output logic ack_o,
  output logic wr_go_o,
  output logic rd_go_o
);
  logic access;
  assign access  = cyc_i && stb_i && !ack_o;
  assign wr_go_o = access && we_i;
  assign rd_go_o = access && !we_i;

  always_ff @(posedge clk) begin
    if (rst) ack_o <= 1'b0;
    else     ack_o <= access;
  end

  assert_ack_bound_R2: assert property (@(posedge clk) disable iff (rst)
    (cyc_i && stb_i && !ack_o) |=> ack_o);
  assert_ack_pulse_R2: assert property (@(posedge clk) disable iff (rst)
    ack_o |=> !ack_o);
endmodule

// File: rtl/uart_reg_store.sv
module uart_reg_store
  import uart_regbank_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_go_i,
  input  logic             rd_go_i,
  input  logic [ADR_W-1:0] adr_i,
  input  logic [REG_W-1:0] dat_i,
  output logic [REG_W-1:0] line_o,
  output logic [REG_W-1:0] ien_o,
  output logic [REG_W-1:0] mdm_o,
  output logic [REG_W-1:0] fifo_ctl_o,
  output logic [REG_W-1:0] scr_o,
  output logic [DIV_W-1:0] div_o,
  output logic [REG_W-1:0] tx_data_o,
  output logic             tx_push_o,
  output logic             rx_pop_o
);
  logic bank;
  assign bank = line_o[BANK_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      line_o     <= LINE_RESET;
      ien_o      <= '0;
      mdm_o      <= '0;
      fifo_ctl_o <= '0;
      scr_o      <= '0;
      div_o      <= '0;
      tx_data_o  <= '0;
      tx_push_o  <= 1'b0;
      rx_pop_o   <= 1'b0;
    end else begin
      tx_push_o <= wr_go_i && (adr_i == ADR_DATA) && !bank;
      rx_pop_o  <= rd_go_i && (adr_i == ADR_DATA) && !bank;
      if (wr_go_i) begin
        case (adr_i)
          ADR_DATA: if (bank) div_o[REG_W-1:0] <= dat_i;
                    else      tx_data_o <= dat_i;
          ADR_IEN:  if (bank) div_o[DIV_W-1:REG_W] <= dat_i;
                    else      ien_o <= dat_i;
          ADR_IDF:  fifo_ctl_o <= dat_i;
          ADR_LINE: line_o <= dat_i;
          ADR_MDM:  mdm_o <= dat_i;
          ADR_SCR:  scr_o <= dat_i;
          default:  ;
        endcase
      end
    end
  end

  assert_line_reset_R1: assert property (@(posedge clk)
    $past(rst) |-> (line_o == LINE_RESET && div_o == '0));
  assert_pop_single_R4: assert property (@(posedge clk) disable iff (rst)
    rx_pop_o |=> !rx_pop_o);
  assert_no_dual_strobe_R13: assert property (@(posedge clk) disable iff (rst)
    !(rx_pop_o && tx_push_o));
endmodule

// File: rtl/uart_read_path.sv
module uart_read_path
  import uart_regbank_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_go_i,
  input  logic [ADR_W-1:0] adr_i,
  input  logic [REG_W-1:0] line_i,
  input  logic [REG_W-1:0] ien_i,
  input  logic [REG_W-1:0] mdm_i,
  input  logic [REG_W-1:0] scr_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic [REG_W-1:0] rx_data_i,
  input  logic             rx_ready_i,
  input  logic             tx_empty_i,
  input  logic             tx_idle_i,
  input  logic [REG_W-1:0] mst_i,
  output logic [REG_W-1:0] dat_o
);
  logic             bank;
  logic [REG_W-1:0] id_byte, lst_byte, nxt;

  assign bank = line_i[BANK_BIT];

  always_comb begin
    if (ien_i[0] && rx_ready_i)      id_byte = ID_RXAVAIL;
    else if (ien_i[1] && tx_empty_i) id_byte = ID_TXEMPTY;
    else                             id_byte = ID_NONE;
  end

  assign lst_byte = {1'b0, tx_empty_i && tx_idle_i, tx_empty_i, 4'b0000, rx_ready_i};

  always_comb begin
    case (adr_i)
      ADR_DATA: nxt = bank ? div_i[REG_W-1:0] : rx_data_i;
      ADR_IEN:  nxt = bank ? div_i[DIV_W-1:REG_W] : ien_i;
      ADR_IDF:  nxt = id_byte;
      ADR_LINE: nxt = line_i;
      ADR_MDM:  nxt = mdm_i;
      ADR_LST:  nxt = lst_byte;
      ADR_MST:  nxt = mst_i;
      default:  nxt = scr_i;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)          dat_o <= '0;
    else if (rd_go_i) dat_o <= nxt;
  end

  assert_thre_R8: assert property (@(posedge clk) disable iff (rst)
    (rd_go_i && adr_i == ADR_LST) |=> (dat_o[5] == $past(tx_empty_i)));
endmodule

// File: rtl/uart_regbank.sv
module uart_regbank
  import uart_regbank_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        wb_cyc_i,
  input  logic        wb_stb_i,
  input  logic        wb_we_i,
  input  logic [2:0]  wb_adr_i,
  input  logic [7:0]  wb_dat_i,
  output logic [7:0]  wb_dat_o,
  output logic        wb_ack_o,
  input  logic [7:0]  rx_data_i,
  input  logic        rx_ready_i,
  input  logic        tx_fifo_empty_i,
  input  logic        tx_shift_idle_i,
  input  logic [7:0]  modem_status_i,
  output logic        rx_pop_o,
  output logic        tx_push_o,
  output logic [7:0]  tx_data_o,
  output logic [7:0]  ier_o,
  output logic [7:0]  fcr_o,
  output logic [7:0]  lcr_o,
  output logic [7:0]  mcr_o,
  output logic [15:0] divisor_o
);
  logic             wr_go, rd_go;
  logic [REG_W-1:0] scr;

  uart_bus_port u_port (
    .clk(clk), .rst(rst), .cyc_i(wb_cyc_i), .stb_i(wb_stb_i), .we_i(wb_we_i),
    .ack_o(wb_ack_o), .wr_go_o(wr_go), .rd_go_o(rd_go)
  );

  uart_reg_store u_store (
    .clk(clk), .rst(rst), .wr_go_i(wr_go), .rd_go_i(rd_go),
    .adr_i(wb_adr_i), .dat_i(wb_dat_i),
    .line_o(lcr_o), .ien_o(ier_o), .mdm_o(mcr_o), .fifo_ctl_o(fcr_o),
    .scr_o(scr), .div_o(divisor_o), .tx_data_o(tx_data_o),
    .tx_push_o(tx_push_o), .rx_pop_o(rx_pop_o)
  );

  uart_read_path u_read (
    .clk(clk), .rst(rst), .rd_go_i(rd_go), .adr_i(wb_adr_i),
    .line_i(lcr_o), .ien_i(ier_o), .mdm_i(mcr_o), .scr_i(scr), .div_i(divisor_o),
    .rx_data_i(rx_data_i), .rx_ready_i(rx_ready_i),
    .tx_empty_i(tx_fifo_empty_i), .tx_idle_i(tx_shift_idle_i),
    .mst_i(modem_status_i), .dat_o(wb_dat_o)
  );

  assert_push_with_ack_R4: assert property (@(posedge clk) disable iff (rst)
    (tx_push_o || rx_pop_o) |-> wb_ack_o);
endmodule

// File: tb/uart_regbank_tb_top.sv
module uart_regbank_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cyc = 0, stb = 0, we = 0;
  logic [2:0] adr = 0;
  logic [7:0] wdat = 0;
  logic [7:0] rdat;
  logic ack;
  logic [7:0] rx_data = 0;
  logic rx_ready = 0, tx_empty = 1, tx_idle = 1;
  logic [7:0] mst = 0;
  logic pop, push;
  logic [7:0] tx_data, ier, fcr, lcr, mcr;
  logic [15:0] divisor;
  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  uart_regbank dut_i (
    .clk(clk), .rst(rst), .wb_cyc_i(cyc), .wb_stb_i(stb), .wb_we_i(we),
    .wb_adr_i(adr), .wb_dat_i(wdat), .wb_dat_o(rdat), .wb_ack_o(ack),
    .rx_data_i(rx_data), .rx_ready_i(rx_ready), .tx_fifo_empty_i(tx_empty),
    .tx_shift_idle_i(tx_idle), .modem_status_i(mst),
    .rx_pop_o(pop), .tx_push_o(push), .tx_data_o(tx_data), .ier_o(ier),
    .fcr_o(fcr), .lcr_o(lcr), .mcr_o(mcr), .divisor_o(divisor)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  logic [7:0] last_q;
  logic       last_pop, last_push;
  int         last_waits;

  task automatic bus(input logic w, input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    cyc = 1; stb = 1; we = w; adr = a; wdat = d;
    last_waits = 0;
    do begin
      @(posedge clk); #1;
      last_waits++;
    end while (!ack && last_waits < 8);
    last_q = rdat; last_pop = pop; last_push = push;
    @(negedge clk);
    cyc = 0; stb = 0; we = 0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    bus(1'b1, a, d);
  endtask

  task automatic rd(input logic [2:0] a);
    bus(1'b0, a, 8'h00);
  endtask

  task automatic t_reset;
    check("R1 lcr_o", lcr, 8'h03);
    check("R1 divisor_o", divisor, 16'h0000);
    rd(3'd3); check("R1 line read", last_q, 8'h03);
    check("R2 ack one cycle after strobe", last_waits, 1);
    @(posedge clk); #1; check("R2 ack released", ack, 0);
    rd(3'd1); check("R1 ier read", last_q, 8'h00);
    rd(3'd4); check("R1 mcr read", last_q, 8'h00);
    rd(3'd7); check("R1 scratch read", last_q, 8'h00);
    rd(3'd2); check("R12 id none", last_q, 8'hC1);
  endtask

  task automatic t_divisor;
    wr(3'd3, 8'h83);
    wr(3'd0, 8'h34); check("R13 no push in divisor bank", last_push, 0);
    wr(3'd1, 8'h12);
    check("R3 divisor_o", divisor, 16'h1234);
    check("R5 ier untouched by bank write", ier, 8'h00);
    rx_ready = 1; rx_data = 8'hEE;
    rd(3'd0); check("R3 divisor low read", last_q, 8'h34);
    check("R13 no pop in divisor bank", last_pop, 0);
    rd(3'd1); check("R3 divisor high read", last_q, 8'h12);
    rd(3'd3); check("R7 line read with bank set", last_q, 8'h83);
    wr(3'd3, 8'h03);
    rx_ready = 0;
  endtask

  task automatic t_data;
    rx_data = 8'hA5; rx_ready = 1;
    rd(3'd0); check("R4 rx data", last_q, 8'hA5);
    check("R4 pop with ack", last_pop, 1);
    @(posedge clk); #1; check("R4 pop one cycle", pop, 0);
    wr(3'd0, 8'h5A); check("R4 push with ack", last_push, 1);
    check("R4 tx data", tx_data, 8'h5A);
    check("R4 divisor kept", divisor, 16'h1234);
    rx_ready = 0;
  endtask

  task automatic t_ien_id;
    wr(3'd1, 8'h03);
    rd(3'd1); check("R5 ier read", last_q, 8'h03);
    check("R5 ier_o", ier, 8'h03);
    rx_ready = 1; tx_empty = 1;
    rd(3'd2); check("R12 rx priority", last_q, 8'hC4);
    rx_ready = 0;
    rd(3'd2); check("R12 tx empty", last_q, 8'hC2);
    tx_empty = 0;
    rd(3'd2); check("R12 none pending", last_q, 8'hC1);
    tx_empty = 1;
    wr(3'd1, 8'h00);
  endtask

  task automatic t_fifo_ctl;
    wr(3'd2, 8'hC7); check("R6 fcr_o", fcr, 8'hC7);
    rd(3'd2); check("R6 read gives id", last_q, 8'hC1);
  endtask

  task automatic t_status;
    tx_empty = 1; tx_idle = 0; rx_ready = 1;
    rd(3'd5); check("R8 thre before idle", last_q, 8'h21);
    tx_empty = 0;
    rd(3'd5); check("R8 tx busy", last_q, 8'h01);
    tx_empty = 1; tx_idle = 1; rx_ready = 0;
    rd(3'd5); check("R8 all empty", last_q, 8'h60);
    mst = 8'hB6;
    rd(3'd6); check("R9 modem status", last_q, 8'hB6);
  endtask

  task automatic t_read_only;
    wr(3'd5, 8'hFF); check("R10 ack on lsr write", last_waits, 1);
    check("R10 no push", last_push, 0);
    wr(3'd6, 8'hFF); check("R10 no pop", last_pop, 0);
    check("R10 lcr kept", lcr, 8'h03);
    check("R10 divisor kept", divisor, 16'h1234);
    check("R10 fcr kept", fcr, 8'hC7);
    check("R10 mcr kept", mcr, 8'h00);
    check("R10 ier kept", ier, 8'h00);
    check("R10 tx data kept", tx_data, 8'h5A);
    rd(3'd7); check("R10 scratch kept", last_q, 8'h00);
    rd(3'd6); check("R10 msr still input", last_q, 8'hB6);
  endtask

  task automatic t_misc;
    wr(3'd4, 8'h1F); rd(3'd4); check("R7 mcr read", last_q, 8'h1F);
    check("R7 mcr_o", mcr, 8'h1F);
    wr(3'd7, 8'h9C); rd(3'd7); check("R11 scratch", last_q, 8'h9C);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    t_reset;
    t_divisor;
    t_data;
    t_ien_id;
    t_fifo_ctl;
    t_status;
    t_read_only;
    t_misc;
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule